// File: doc/BRIEF.md
# Token-Passing Frame Serializer

This block converts one network frame at a time into a pulse-encoded serial line stream for a token-passing bus. The host selects a frame type and supplies its fields on parallel inputs: destination node, source node and payload length. Payload bytes are pulled one at a time from a byte port while the frame goes out. The block generates the check sequence itself, frames every character, and drives two active-low pulse lines. A one-bit is a pair of non-overlapping pulses. A zero-bit leaves both lines high.

A frame starts with a burst of six one-bits. The characters of the chosen frame type follow back to back. `tx_en` is high for the whole frame. A one-cycle `done` strobe marks the end of the frame. Reception, line arbitration, protocol timers and the analog line drivers are handled elsewhere.

Top module: `arc_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released, `tx_en`, `done` and `pay_rd` are 0 and both `pulse_a_n` and `pulse_b_n` are 1 until a frame is started.
- R2: Every frame begins with six consecutive one-bit intervals before its first character.
- R3: Each character takes exactly 11 bit intervals with no idle interval between characters. The intervals carry 1, 1, 0 and then the eight character bits, least significant first.
- R4: A bit interval lasts BIT_CYC clocks. For a one-bit, `pulse_a_n` is low for the first PULSE_CYC clocks of the interval and `pulse_b_n` is low for the next PULSE_CYC clocks. For a zero-bit both lines stay high. The two lines are never low together.
- R5: Type code 0 sends the token frame: character 04h, then the destination ID twice.
- R6: Type code 1 sends the buffer enquiry: character 85h, then the destination ID twice.
- R7: Type code 2 sends the data frame, in this order: 01h, source ID, destination ID twice, the length byte, that many payload bytes, then the check value low byte and then its high byte.
- R8: Type code 3 sends the single character 86h (acknowledge). Type code 4 sends the single character 15h (refusal).
- R9: The check value is a CRC-16 with polynomial x^16+x^15+x^2+1, processed least significant bit first (reflected constant A001h), starting from 0000h. It covers the source ID through the last payload byte.
- R10: `pay_rd` is high for one clock for each payload byte, and `pay_data` is taken in that same clock. There are exactly as many strobes as the length value. A length of 0 gives no strobe, and the check value follows the length byte directly.
- R11: A `start` seen in an idle clock with a valid type raises `tx_en` from the next clock until the last bit interval ends. `done` is high for exactly the one clock in which `tx_en` has just fallen.
- R12: `start` has no effect while a frame is being sent, or when the type code is 5 to 7. The type, IDs and length are captured when a frame is accepted, so later changes to those inputs do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send a frame |
| frame_type | input | 3 | Frame type code (0 to 4) |
| dest_id | input | 8 | Destination node ID |
| src_id | input | 8 | Source node ID |
| pay_len | input | 8 | Number of payload bytes in a data frame |
| pay_data | input | 8 | Payload byte, taken while pay_rd is high |
| pay_rd | output | 1 | Payload byte fetch strobe |
| tx_en | output | 1 | High while a frame is on the line |
| pulse_a_n | output | 1 | First pulse line, active low |
| pulse_b_n | output | 1 | Second pulse line, active low |
| done | output | 1 | One-clock end-of-frame strobe |

## Verification
The bench rebuilds every expected line waveform clock by clock from the bit sequence of each frame type. A wrong character code, a missing duplicate destination byte, or a misplaced pulse phase therefore appears as a waveform mismatch. Data frames with lengths of 0, 3 and 255 test the sequencing at its boundaries. A design that sent a payload byte for length 0, or one byte too many or too few, would show a wrong strobe count and a shifted check value. The check value is computed in the bench bit by bit, so a wrong polynomial, bit order or coverage range shows up in the last two characters. Other cases cover a `start` with new field values in the middle of a frame and a `start` with an unused type code. A design that restarted the frame or read the inputs live would corrupt the stream or send a frame where none should go.

// File: rtl/arc_tx_pkg.sv
package arc_tx_pkg;

  localparam int BYTE_W    = 8;
  localparam int SYM_W     = 11;
  localparam int SYM_CNT_W = 4;

  typedef enum logic [2:0] {
    FT_TOKEN = 3'd0,
    FT_ENQ   = 3'd1,
    FT_DATA  = 3'd2,
    FT_ACK   = 3'd3,
    FT_NAK   = 3'd4
  } ftype_e;

  typedef enum logic [3:0] {
    SP_LEAD, SP_SID, SP_DID_A, SP_DID_B, SP_CNT,
    SP_PAY, SP_CRC_LO, SP_CRC_HI, SP_END
  } step_e;

  localparam logic [BYTE_W-1:0] CH_TOKEN = 8'h04;
  localparam logic [BYTE_W-1:0] CH_ENQ   = 8'h85;
  localparam logic [BYTE_W-1:0] CH_DATA  = 8'h01;
  localparam logic [BYTE_W-1:0] CH_ACK   = 8'h86;
  localparam logic [BYTE_W-1:0] CH_NAK   = 8'h15;

  localparam logic [SYM_W-1:0]     ALERT_SYM  = 11'b000_0011_1111;
  localparam logic [SYM_CNT_W-1:0] ALERT_LAST = 4'd5;
  localparam logic [SYM_CNT_W-1:0] CHAR_LAST  = 4'd10;

  function automatic logic type_valid(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic [BYTE_W-1:0] lead_char(input ftype_e t);
    case (t)
      FT_TOKEN: return CH_TOKEN;
      FT_ENQ:   return CH_ENQ;
      FT_DATA:  return CH_DATA;
      FT_ACK:   return CH_ACK;
      default:  return CH_NAK;
    endcase
  endfunction

  // Character framing: two ones, a zero, then data LSB first (bit 0 leaves first)
  function automatic logic [SYM_W-1:0] char_sym(input logic [BYTE_W-1:0] b);
    return {b, 3'b011};
  endfunction

  // Reflected CRC-16, one byte folded in
  function automatic logic [15:0] crc_fold(input logic [15:0] c, input logic [BYTE_W-1:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    end
    return r;
  endfunction

  function automatic step_e step_after(input ftype_e t, input step_e s,
                                       input logic [BYTE_W-1:0] len,
                                       input logic [BYTE_W-1:0] rem);
    case (s)
      SP_LEAD:   return (t == FT_DATA) ? SP_SID :
                        ((t == FT_TOKEN) || (t == FT_ENQ)) ? SP_DID_A : SP_END;
      SP_SID:    return SP_DID_A;
      SP_DID_A:  return SP_DID_B;
      SP_DID_B:  return (t == FT_DATA) ? SP_CNT : SP_END;
      SP_CNT:    return (len == '0) ? SP_CRC_LO : SP_PAY;
      SP_PAY:    return (rem == 8'd1) ? SP_CRC_LO : SP_PAY;
      SP_CRC_LO: return SP_CRC_HI;
      default:   return SP_END;
    endcase
  endfunction

endpackage

// File: rtl/arc_bit_timer.sv
module arc_bit_timer #(
  parameter int BIT_CYC   = 20,
  parameter int PULSE_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_val,
  output logic bit_end,
  output logic pulse_a_n,
  output logic pulse_b_n
);
  localparam int PH_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYC - 1);
  localparam logic [PH_W-1:0] PH_A    = PH_W'(PULSE_CYC);
  localparam logic [PH_W-1:0] PH_B    = PH_W'(2 * PULSE_CYC);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    phase <= '0;
    else if (!run || bit_end)      phase <= '0;
    else                           phase <= phase + 1'b1;
  end

  assign bit_end   = run && (phase == PH_LAST);
  assign pulse_a_n = !(run && bit_val && (phase < PH_A));
  assign pulse_b_n = !(run && bit_val && (phase >= PH_A) && (phase < PH_B));

endmodule

// File: rtl/arc_sym_shifter.sv
module arc_sym_shifter
  import arc_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [SYM_W-1:0]     load_sym,
  input  logic [SYM_CNT_W-1:0] load_last,
  input  logic                 advance,
  output logic                 cur_bit,
  output logic                 last_bit
);
  logic [SYM_W-1:0]     sreg;
  logic [SYM_CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= load_sym;
      left <= load_last;
    end else if (advance) begin
      sreg <= {1'b0, sreg[SYM_W-1:1]};
      if (left != '0) left <= left - 1'b1;
    end
  end

  assign cur_bit  = sreg[0];
  assign last_bit = (left == '0);

endmodule

// File: rtl/arc_frame_seq.sv
module arc_frame_seq
  import arc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        ftype_in,
  input  logic [BYTE_W-1:0] did_in,
  input  logic [BYTE_W-1:0] sid_in,
  input  logic [BYTE_W-1:0] len_in,
  input  logic [BYTE_W-1:0] pay_data,
  input  logic              sym_end,
  output logic              busy,
  output logic              done,
  output logic              pay_rd,
  output logic              load_alert,
  output logic              load_char,
  output logic [BYTE_W-1:0] char_out
);
  ftype_e            ft_q;
  step_e             step_q;
  logic [BYTE_W-1:0] did_q, sid_q, len_q, rem_q;
  logic [15:0]       crc_q;
  logic              finish;
  logic              in_crc_span;

  assign load_alert  = start && !busy && type_valid(ftype_in);
  assign load_char   = sym_end && busy && (step_q != SP_END);
  assign finish      = sym_end && busy && (step_q == SP_END);
  assign pay_rd      = load_char && (step_q == SP_PAY);
  assign in_crc_span = (step_q == SP_SID) || (step_q == SP_DID_A) || (step_q == SP_DID_B) ||
                       (step_q == SP_CNT) || (step_q == SP_PAY);

  always_comb begin
    case (step_q)
      SP_LEAD:             char_out = lead_char(ft_q);
      SP_SID:              char_out = sid_q;
      SP_DID_A, SP_DID_B:  char_out = did_q;
      SP_CNT:              char_out = len_q;
      SP_PAY:              char_out = pay_data;
      SP_CRC_LO:           char_out = crc_q[7:0];
      SP_CRC_HI:           char_out = crc_q[15:8];
      default:             char_out = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      ft_q   <= FT_TOKEN;
      step_q <= SP_END;
      did_q  <= '0;
      sid_q  <= '0;
      len_q  <= '0;
      rem_q  <= '0;
      crc_q  <= '0;
    end else begin
      done <= finish;
      if (load_alert) begin
        busy   <= 1'b1;
        ft_q   <= ftype_e'(ftype_in);
        step_q <= SP_LEAD;
        did_q  <= did_in;
        sid_q  <= sid_in;
        len_q  <= len_in;
        rem_q  <= '0;
        crc_q  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (load_char) begin
        step_q <= step_after(ft_q, step_q, len_q, rem_q);
        if (in_crc_span)           crc_q <= crc_fold(crc_q, char_out);
        if (step_q == SP_CNT)      rem_q <= len_q;
        else if (step_q == SP_PAY) rem_q <= rem_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/arc_frame_tx.sv
module arc_frame_tx
  import arc_tx_pkg::*;
#(
  parameter int BIT_CYC   = 20,
  parameter int PULSE_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] frame_type,
  input  logic [7:0] dest_id,
  input  logic [7:0] src_id,
  input  logic [7:0] pay_len,
  input  logic [7:0] pay_data,
  output logic       pay_rd,
  output logic       tx_en,
  output logic       pulse_a_n,
  output logic       pulse_b_n,
  output logic       done
);
  logic              busy;
  logic              bit_end;
  logic              cur_bit;
  logic              last_bit;
  logic              sym_end;
  logic              load_alert;
  logic              load_char;
  logic [BYTE_W-1:0] char_out;
  logic [SYM_W-1:0]     sym_in;
  logic [SYM_CNT_W-1:0] sym_last;

  assign sym_end  = bit_end && last_bit;
  assign sym_in   = load_alert ? ALERT_SYM  : char_sym(char_out);
  assign sym_last = load_alert ? ALERT_LAST : CHAR_LAST;
  assign tx_en    = busy;

  arc_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ftype_in   (frame_type),
    .did_in     (dest_id),
    .sid_in     (src_id),
    .len_in     (pay_len),
    .pay_data   (pay_data),
    .sym_end    (sym_end),
    .busy       (busy),
    .done       (done),
    .pay_rd     (pay_rd),
    .load_alert (load_alert),
    .load_char  (load_char),
    .char_out   (char_out)
  );

  arc_sym_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_alert || load_char),
    .load_sym  (sym_in),
    .load_last (sym_last),
    .advance   (bit_end),
    .cur_bit   (cur_bit),
    .last_bit  (last_bit)
  );

  arc_bit_timer #(.BIT_CYC(BIT_CYC), .PULSE_CYC(PULSE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .bit_val   (cur_bit),
    .bit_end   (bit_end),
    .pulse_a_n (pulse_a_n),
    .pulse_b_n (pulse_b_n)
  );

endmodule

// File: rtl/arc_frame_tx_chk.sv
module arc_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic pulse_a_n,
  input logic pulse_b_n,
  input logic done,
  input logic pay_rd,
  input logic bit_end,
  input logic cur_bit
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!pulse_a_n && !pulse_b_n)); // R4
  AST_B_AFTER_A: assert property (@(posedge clk) disable iff (!rst_n) $fell(pulse_b_n) |-> $past(!pulse_a_n)); // R4
  AST_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n) tx_en && !bit_end |=> $stable(cur_bit)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |-> pulse_a_n && pulse_b_n); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) done |-> !tx_en && $past(tx_en)); // R11
  AST_RD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) pay_rd |-> tx_en && bit_end); // R10
  AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n) tx_en && !bit_end |=> tx_en); // R12
endmodule

bind arc_frame_tx arc_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .pulse_a_n (pulse_a_n),
  .pulse_b_n (pulse_b_n),
  .done      (done),
  .pay_rd    (pay_rd),
  .bit_end   (bit_end),
  .cur_bit   (cur_bit)
);

// File: tb/arc_frame_tx_test.sv
`timescale 1ns/1ps
module arc_frame_tx_test;
  localparam int BC = 20;
  localparam int PW = 5;
  localparam int MAXB = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] frame_type = 3'd0;
  logic [7:0] dest_id = 8'h00, src_id = 8'h00, pay_len = 8'h00;
  logic [7:0] pay_data;
  logic       pay_rd, tx_en, pulse_a_n, pulse_b_n, done;

  logic [7:0] pay_mem [0:255];
  logic [7:0] pay_idx;
  logic       pay_clr = 1'b0;
  logic       exp_bits [0:MAXB-1];
  int         nbits;
  int         checks = 0;
  int         fails = 0;

  always #10 clk = ~clk;

  arc_frame_tx #(.BIT_CYC(BC), .PULSE_CYC(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_type(frame_type),
    .dest_id(dest_id), .src_id(src_id), .pay_len(pay_len), .pay_data(pay_data),
    .pay_rd(pay_rd), .tx_en(tx_en), .pulse_a_n(pulse_a_n), .pulse_b_n(pulse_b_n),
    .done(done)
  );

  assign pay_data = pay_mem[pay_idx];
  always @(posedge clk) begin
    if (pay_clr)     pay_idx <= 8'h00;
    else if (pay_rd) pay_idx <= pay_idx + 8'h01;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] bit_crc(input logic [15:0] c, input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[i];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

  task automatic put_bit(input logic b);
    exp_bits[nbits] = b;
    nbits++;
  endtask

  task automatic put_char(input logic [7:0] ch);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(ch[i]);
  endtask

  // Builds the expected bit stream, sends a frame, checks it clock by clock.
  // poke_at >= 0 raises start with altered fields at that clock of the frame.
  task automatic run_frame(input logic [2:0] t, input logic [7:0] did, input logic [7:0] sid,
                           input logic [7:0] len, input int poke_at, input string req);
    logic [15:0] crc;
    int mism, first_c, rdc;
    logic [2:0] act3, exp3;
    nbits = 0;
    for (int i = 0; i < 6; i++) put_bit(1'b1);  // R2 alert
    case (t)
      3'd0: begin put_char(8'h04); put_char(did); put_char(did); end
      3'd1: begin put_char(8'h85); put_char(did); put_char(did); end
      3'd2: begin
        crc = 16'h0000;
        put_char(8'h01);
        put_char(sid); crc = bit_crc(crc, sid);
        put_char(did); crc = bit_crc(crc, did);
        put_char(did); crc = bit_crc(crc, did);
        put_char(len); crc = bit_crc(crc, len);
        for (int k = 0; k < len; k++) begin
          put_char(pay_mem[k]); crc = bit_crc(crc, pay_mem[k]);
        end
        put_char(crc[7:0]); put_char(crc[15:8]);
      end
      3'd3: put_char(8'h86);
      default: put_char(8'h15);
    endcase
    @(negedge clk);
    pay_clr = 1'b1; frame_type = t; dest_id = did; src_id = sid; pay_len = len; start = 1'b1;
    @(negedge clk);
    pay_clr = 1'b0; start = 1'b0;
    mism = 0; first_c = -1; rdc = 0; act3 = '0; exp3 = '0;
    for (int c = 0; c < nbits * BC; c++) begin
      logic b, ea, eb;
      int ph;
      b  = exp_bits[c / BC];
      ph = c % BC;
      ea = !(b && ph < PW);
      eb = !(b && ph >= PW && ph < 2 * PW);
      if ({tx_en, pulse_a_n, pulse_b_n} !== {1'b1, ea, eb}) begin
        if (mism == 0) begin
          first_c = c; act3 = {tx_en, pulse_a_n, pulse_b_n}; exp3 = {1'b1, ea, eb};
        end
        mism++;
      end
      if (pay_rd) rdc++;
      if (c == poke_at) begin
        start = 1'b1; dest_id = ~did; src_id = ~sid; pay_len = len + 8'd1; frame_type = 3'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (mism != 0) $display("  first mismatch at clock %0d of frame", first_c);
    chk(mism == 0, req, "line waveform {tx_en,a_n,b_n}", act3, exp3);
    chk(tx_en == 1'b0 && done == 1'b1, "R11", "end {tx_en,done}", {tx_en, done}, 2'b01);
    chk(rdc == ((t == 3'd2) ? int'(len) : 0), "R10", "payload strobes", rdc, (t == 3'd2) ? len : 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one clock", done, 0);
  endtask

  task automatic test_reset();
    chk({tx_en, done, pay_rd, pulse_a_n, pulse_b_n} == 5'b00011, "R1", "in reset",
        {tx_en, done, pay_rd, pulse_a_n, pulse_b_n}, 5'b00011);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({tx_en, done, pay_rd, pulse_a_n, pulse_b_n} == 5'b00011, "R1", "after reset",
        {tx_en, done, pay_rd, pulse_a_n, pulse_b_n}, 5'b00011);
  endtask

  task automatic test_token();  run_frame(3'd0, 8'h5A, 8'h00, 8'h00, -1, "R5"); endtask
  task automatic test_enq();    run_frame(3'd1, 8'hC3, 8'h00, 8'h00, -1, "R6"); endtask
  task automatic test_ack_nak();
    run_frame(3'd3, 8'h11, 8'h22, 8'h00, -1, "R8");
    run_frame(3'd4, 8'h11, 8'h22, 8'h00, -1, "R8");
  endtask
  task automatic test_data_small(); run_frame(3'd2, 8'h7E, 8'h81, 8'd3, -1, "R7 R9"); endtask
  task automatic test_data_empty(); run_frame(3'd2, 8'h01, 8'hFE, 8'd0, -1, "R10 R9"); endtask
  task automatic test_data_full();  run_frame(3'd2, 8'hA5, 8'h3C, 8'd255, -1, "R7 R3"); endtask
  task automatic test_busy_start(); run_frame(3'd2, 8'h44, 8'h99, 8'd2, 7 * BC, "R12"); endtask

  task automatic test_bad_type();
    int seen;
    @(negedge clk);
    frame_type = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0; frame_type = 3'd0;
    seen = 0;
    for (int c = 0; c < 3 * BC; c++) begin
      if (tx_en || pay_rd || done || !pulse_a_n || !pulse_b_n) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R12", "unused type code activity clocks", seen, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pay_mem[i] = 8'(i * 37 + 11);
    @(negedge clk);
    test_reset();
    test_token();
    test_enq();
    test_ack_nak();
    test_data_small();
    test_data_empty();
    test_busy_start();
    test_bad_type();
    test_data_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule